// File: doc/BRIEF.md
# Byte-Writable Synchronous RAM Core

This block is a single-port synchronous RAM of 32-bit words split into four 8-bit byte lanes. The address and the write controls are sampled on the rising clock edge. Read data is not registered: it comes straight from the array, addressed by the registered address, so a read issued on one edge returns its word before the next edge. An external sequencer supplies every address.

Writes have two levels of control, both active low. A global write stores the whole word. When the global write is inactive, a byte-write enable together with four per-lane selects stores any subset of the lanes. When neither is active, the cycle is a read. A sleep input stops all internal clocking and keeps the contents. An asynchronous output enable gates the read data. The tristate data pins are split into a write bus, a read bus and a read-valid flag.

The depth is set by `ADDR_W`. The full 32,768-word array uses `ADDR_W = 15`. The default is 1,024 words so that elaboration stays small.

Top module: `sram_bytewr_core`

## Requirements
- R1: The array holds 2**ADDR_W words of four 8-bit lanes. Lane k is `wdata`/`rdata` bits 8k+7:8k and is controlled by `bsel_n[k]`.
- R2: With `gw_n` low at a rising edge, all four lanes of the word at `addr` are written from `wdata`, whatever `bwe_n` and `bsel_n` hold.
- R3: With `gw_n` high and `bwe_n` low at an edge, lane k is written only if `bsel_n[k]` is low. Any number of lanes may be written in the same cycle.
- R4: With `gw_n` and `bwe_n` both high at an edge, the cycle is a read and no lane of the array changes.
- R5: After a read edge at address A, while `oe_n` is low and `sleep` is low, `rvalid` is 1 and `rdata` equals the stored word at A within that same cycle, before the next edge.
- R6: A read of an address written at the previous edge returns the newly written data.
- R7: While `sleep` is high, rising edges capture nothing and write nothing. The stored contents are unchanged when sleep is released.
- R8: While `sleep` is high, `rvalid` is 0 and `rdata` is zero.
- R9: `oe_n` acts without a clock. While it is high, `rvalid` is 0 and `rdata` is zero. When it goes low again, the read word reappears in the same cycle.
- R10: While `rst_n` is low, and after reset until the first read edge, `rvalid` is 0.
- R11: In the cycle after a write edge (R2 or R3), `rvalid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control registers |
| sleep | input | 1 | High stops internal clocking; contents kept |
| addr | input | ADDR_W | Word address, sampled at the edge |
| gw_n | input | 1 | Global write, active low, writes all lanes |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | 4 | Per-lane write selects, active low |
| wdata | input | 32 | Write data, sampled at the edge |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | 32 | Read data (zero when not valid) |
| rvalid | output | 1 | Read data valid |

## Verification
The hardest situation to bring about is a sleep interval that overlaps pending traffic. A write is attempted while sleep is high, and then the same address is read right after release. This must expose the old word, and the registered address must not have moved. Random stimulus keeps its addresses in a 16-word window so that back-to-back write/read hits on one word occur often. It raises sleep about one cycle in sixteen, and directed sequences force the sleep-write-then-read pattern and toggle `oe_n` between edges.

// File: rtl/sram_pkg.sv
package sram_pkg;
  // Lane write strobes (1 = write) from the active-low controls.
  // The global write dominates, the byte path needs its enable,
  // and otherwise the cycle is a read.
  function automatic logic [31:0] lane_wr_en(input logic gw_n, input logic bwe_n,
                                             input logic [31:0] sel_n);
    if (!gw_n)       return '1;
    else if (!bwe_n) return ~sel_n;
    else             return '0;
  endfunction

  // A cycle is a read when neither write path is active.
  function automatic logic is_read(input logic gw_n, input logic bwe_n);
    return gw_n && bwe_n;
  endfunction
endpackage

// File: rtl/sram_capture.sv
module sram_capture #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_cmd,
  output logic [ADDR_W-1:0] addr_q,
  output logic              rd_q
);
  // Registers only advance while the internal clock is running.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rd_q   <= 1'b0;
    end else if (run) begin
      addr_q <= addr;
      rd_q   <= rd_cmd;
    end
  end
endmodule

// File: rtl/sram_lane_bank.sv
module sram_lane_bank #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [LANE_W-1:0] wbyte,
  input  logic [ADDR_W-1:0] raddr,
  output logic [LANE_W-1:0] rbyte
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wbyte;
  end

  // Flow-through read: no register between the array and the output.
  assign rbyte = cells[raddr];
endmodule

// File: rtl/sram_bytewr_core.sv
module sram_bytewr_core
  import sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sleep,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      gw_n,
  input  logic                      bwe_n,
  input  logic [LANES-1:0]          bsel_n,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic                      oe_n,
  output logic [LANES*LANE_W-1:0]   rdata,
  output logic                      rvalid
);
  localparam int WORD_W = LANES * LANE_W;

  // Internal events, named for the checker.
  logic                run;
  logic                rd_cmd;
  logic [LANES-1:0]    lane_we;
  logic [ADDR_W-1:0]   addr_q;
  logic                rd_q;
  logic [WORD_W-1:0]   word_rd;
  logic [31:0]         sel_ext;
  logic [31:0]         we_ext;

  assign run     = !sleep;
  assign rd_cmd  = is_read(gw_n, bwe_n);
  assign sel_ext = 32'(bsel_n);
  assign we_ext  = lane_wr_en(gw_n, bwe_n, sel_ext);
  assign lane_we = we_ext[LANES-1:0] & {LANES{run}};

  sram_capture #(.ADDR_W(ADDR_W)) i_capture (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .addr   (addr),
    .rd_cmd (rd_cmd),
    .addr_q (addr_q),
    .rd_q   (rd_q)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    sram_lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) i_bank (
      .clk   (clk),
      .we    (lane_we[k]),
      .waddr (addr),
      .wbyte (wdata[k*LANE_W +: LANE_W]),
      .raddr (addr_q),
      .rbyte (word_rd[k*LANE_W +: LANE_W])
    );
  end

  assign rvalid = rd_q && run && !oe_n;
  assign rdata  = rvalid ? word_rd : '0;
endmodule

// File: rtl/sram_bytewr_chk.sv
module sram_bytewr_chk #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sleep,
  input logic                    gw_n,
  input logic                    bwe_n,
  input logic                    oe_n,
  input logic                    rvalid,
  input logic [LANES*LANE_W-1:0] rdata,
  input logic [LANES-1:0]        lane_we,
  input logic [ADDR_W-1:0]       addr_q
);
  // R8
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!rvalid && rdata == '0));
  // R9
  oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!rvalid && rdata == '0));
  // R7
  sleep_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> lane_we == '0);
  // R7
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(addr_q));
  // R2
  gw_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gw_n && !sleep) |-> lane_we == '1);
  // R4
  rd_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gw_n && bwe_n) |-> lane_we == '0);
  // R11
  write_novld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!gw_n || !bwe_n) && !sleep) |=> !rvalid);
endmodule

bind sram_bytewr_core sram_bytewr_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sleep   (sleep),
  .gw_n    (gw_n),
  .bwe_n   (bwe_n),
  .oe_n    (oe_n),
  .rvalid  (rvalid),
  .rdata   (rdata),
  .lane_we (lane_we),
  .addr_q  (addr_q)
);

// File: tb/test_sram_bytewr_core.sv
module test_sram_bytewr_core;
  localparam int ADDR_W = 10;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sleep = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              gw_n = 1'b1;
  logic              bwe_n = 1'b1;
  logic [3:0]        bsel_n = 4'hF;
  logic [31:0]       wdata = '0;
  logic              oe_n = 1'b0;
  logic [31:0]       rdata;
  logic              rvalid;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model [DEPTH];

  always #4 clk = ~clk;

  sram_bytewr_core #(.ADDR_W(ADDR_W)) i_sram_bytewr_core (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .addr(addr), .gw_n(gw_n),
    .bwe_n(bwe_n), .bsel_n(bsel_n), .wdata(wdata), .oe_n(oe_n),
    .rdata(rdata), .rvalid(rvalid)
  );

  // Bench restatement of the write rules, built per lane.
  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic g, input logic b, input logic [3:0] s);
    logic [31:0] r = old;
    for (int k = 0; k < 4; k++)
      if (!g || (!b && !s[k])) r[8*k +: 8] = nw[8*k +: 8];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a negedge, take one edge, check at the following negedge.
  task automatic step(input string req, input logic g, input logic b, input logic [3:0] s,
                      input logic [ADDR_W-1:0] a, input logic [31:0] d,
                      input logic o, input logic sl);
    logic rd;
    gw_n = g; bwe_n = b; bsel_n = s; addr = a; wdata = d; oe_n = o; sleep = sl;
    rd = g && b;
    @(posedge clk);
    if (!sl) model[a] = merge(model[a], d, g, b, s);
    @(negedge clk);
    if (sl) begin
      chk({req, " R8 vld"}, 32'(rvalid), 32'd0);
      chk({req, " R8 data"}, rdata, 32'd0);
    end else if (!rd) begin
      chk({req, " R11"}, 32'(rvalid), 32'd0);
    end else begin
      chk({req, " vld"}, 32'(rvalid), 32'(!o));
      chk({req, " data"}, rdata, o ? 32'd0 : model[a]);
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    chk("R10 in reset", 32'(rvalid), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R10 after reset", 32'(rvalid), 32'd0);

    // Fill the whole array through the global write, byte controls set to block.
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = 'x;
      step("R2 fill", 1'b0, 1'b0, 4'hF, ADDR_W'(i), 32'hA5000000 ^ (32'(i) * 32'h9E37_79B9), 1'b0, 1'b0);
    end
    step("R2 R5 readback", 1'b1, 1'b1, 4'h0, 10'd7, 32'hFFFF_FFFF, 1'b0, 1'b0);

    // R1 lane mapping: one lane at a time, then read.
    for (int k = 0; k < 4; k++) begin
      step("R1 R3 lane", 1'b1, 1'b0, ~(4'b1 << k), 10'd20, 32'h11223344 << k, 1'b0, 1'b0);
      step("R1 R6 lane read", 1'b1, 1'b1, 4'h0, 10'd20, 32'h0, 1'b0, 1'b0);
    end
    // R3 multiple lanes in one cycle.
    step("R3 multi", 1'b1, 1'b0, 4'b0101, 10'd21, 32'hDEAD_BEEF, 1'b0, 1'b0);
    step("R3 R6 multi read", 1'b1, 1'b1, 4'h0, 10'd21, 32'h0, 1'b0, 1'b0);
    // R4 read twice leaves the word unchanged.
    step("R4 read a", 1'b1, 1'b1, 4'h0, 10'd21, 32'h1234_5678, 1'b0, 1'b0);
    step("R4 read b", 1'b1, 1'b1, 4'h0, 10'd21, 32'h8765_4321, 1'b0, 1'b0);

    // R7: write attempted during sleep is lost, then read after release.
    step("R6 pre", 1'b0, 1'b1, 4'hF, 10'd30, 32'hCAFE_0001, 1'b0, 1'b0);
    step("R7 R8 sleep write", 1'b0, 1'b0, 4'h0, 10'd30, 32'h0BAD_0BAD, 1'b0, 1'b1);
    step("R7 R8 sleep read", 1'b1, 1'b1, 4'h0, 10'd31, 32'h0, 1'b0, 1'b1);
    step("R7 wake read", 1'b1, 1'b1, 4'h0, 10'd30, 32'h0, 1'b0, 1'b0);

    // R9: asynchronous output enable between edges.
    oe_n = 1'b1; #1;
    chk("R9 oe off vld", 32'(rvalid), 32'd0);
    chk("R9 oe off data", rdata, 32'd0);
    oe_n = 1'b0; #1;
    chk("R9 oe on vld", 32'(rvalid), 32'd1);
    chk("R9 oe on data", rdata, model[30]);
    @(negedge clk);

    // Random traffic in a small window so write/read hits repeat.
    for (int n = 0; n < 4000; n++) begin
      automatic logic g  = ($urandom % 4) != 0;
      automatic logic b  = ($urandom % 2) != 0;
      automatic logic o  = ($urandom % 8) == 0;
      automatic logic sl = ($urandom % 16) == 0;
      step("R5 R6 random", g, b, 4'($urandom), ADDR_W'($urandom % 16), $urandom, o, sl);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
  end
endmodule